// File: doc/BRIEF.md
# Receive Character Queue with Line Status Word

This block sits between a serial deserializer and a CPU-facing register file. Each time the deserializer completes a character it raises a one-cycle strobe with the byte and three error tags: break, framing and parity. The block stores the character and its tags together in a queue whose depth is a parameter, 16 by default. The CPU pops the oldest character through a data-register read strobe and sees the status through an 8-bit line status word.

The three error tags of a character reach the status word only while that character is the oldest one in the queue. Overrun is different. It is kept as a sticky flag that appears as soon as a character is lost. A status-register read strobe clears overrun and hides the tags of the current head until a different character becomes the head. Two further status bits come from the transmit side. One reflects an empty transmit holding stage (holding register or transmit queue). The other is set only when that stage and the transmit shift register are both empty.

When queue mode is off, the store acts as a single holding register, and a new character overwrites an unread one. Any change of the mode input empties the store.

Top module: `rx_fifo_lsr`

## Requirements
- R1: After reset the store is empty, `rd_byte` is 0 and status bits 4 down to 0 and bit 7 are 0.
- R2: In queue mode characters come out of `rd_byte` in arrival order. A `rd_data` strobe pops the head. Status bit 0 (data ready) is 1 from the cycle after a character is stored until the cycle after the last stored character is popped. `rd_byte` reads 0 while the store is empty.
- R3: Status bits 4, 3 and 2 equal the break, framing and parity tags of the character currently at the head of the store, and are 0 when the store is empty.
- R4: A `rd_status` strobe clears status bit 1 (overrun) and masks bits 4..2 until a different character becomes the head. If an overrun event happens in the same cycle as the strobe, the overrun flag stays set.
- R5: In queue mode, a character that completes while the store holds DEPTH entries and no pop happens in that cycle sets status bit 1. That character is discarded and the stored contents are unchanged.
- R6: A character that completes in the same cycle as a pop is stored, even when the store is full, and the number of stored entries stays the same.
- R7: In queue mode, status bit 7 is 1 while at least one stored entry carries any error tag. In single-register mode it is 0.
- R8: In single-register mode the store holds one character. A second character that arrives before the first has been popped replaces it and sets status bit 1.
- R9: Status bit 5 equals `tx_hold_empty`. Status bit 6 equals `tx_hold_empty` AND `tx_shift_empty`.
- R10: A change of `fifo_en` empties the store in the next cycle and drops any character that completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| char_done | input | 1 | One-cycle strobe: a received character is complete |
| char_data | input | 8 | Received character |
| char_brk | input | 1 | Break tag of the received character |
| char_frm | input | 1 | Framing error tag of the received character |
| char_par | input | 1 | Parity error tag of the received character |
| rd_data | input | 1 | CPU read of the data register; pops the head |
| rd_status | input | 1 | CPU read of the status register |
| tx_hold_empty | input | 1 | Transmit holding stage is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| rd_byte | output | 8 | Head character, 0 when empty |
| status | output | 8 | Line status word |

## Verification
The bench fills the queue to exactly DEPTH and then delivers one more character. A design that stored that character, or that reported overrun one entry too early, would return a seventeenth byte or raise bit 1 with room still left. It completes a character on the same cycle as a pop while the queue is full; a design that checked fullness before the pop would wrongly flag overrun and lose the byte. It reads status while a tagged character is at the head and then queues a second tagged character behind it. A design that let tags leak from non-head entries, or that cleared the mask without a head change, would show the wrong error bits. It also drives an overrun and a status read in the same cycle, toggles the mode with data present, and overwrites the holding register in single-register mode.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       brk;
    logic       frm;
    logic       par;
  } rx_entry_t;

  localparam int unsigned ST_DR   = 0;
  localparam int unsigned ST_OE   = 1;
  localparam int unsigned ST_PE   = 2;
  localparam int unsigned ST_FE   = 3;
  localparam int unsigned ST_BI   = 4;
  localparam int unsigned ST_THRE = 5;
  localparam int unsigned ST_TEMT = 6;
  localparam int unsigned ST_QERR = 7;

endpackage

// File: rtl/rxls_store.sv
module rxls_store
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic          wr_over,
  input  rx_entry_t     wr_entry,
  input  logic          rd_en,
  output rx_entry_t     head,
  output logic [CW-1:0] count
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] rptr_q, rptr_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (rd_en) rptr_d = bump(rptr_q);
      if (wr_en) wptr_d = bump(wptr_q);
      case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && wr_en)        mem[wptr_q] <= wr_entry;
    else if (!flush && wr_over) mem[rptr_q] <= wr_entry;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !flush) |=> $stable(cnt_q));

endmodule

// File: rtl/rxls_tagcnt.sv
module rxls_tagcnt #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic any_tag
);

  logic [CW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    tcnt_d = tcnt_q;
    if (clr) tcnt_d = '0;
    else begin
      case ({inc, dec})
        2'b10:   tcnt_d = tcnt_q + 1'b1;
        2'b01:   tcnt_d = tcnt_q - 1'b1;
        default: tcnt_d = tcnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  assign any_tag = (tcnt_q != '0);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !inc) |-> (tcnt_q != '0));

  a_r7_no_overcount: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt_q <= CW'(DEPTH));

endmodule

// File: rtl/rxls_status.sv
module rxls_status
  import rxls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       ovr_evt,
  input  logic       rd_status,
  input  logic       head_change,
  input  logic       nonempty,
  input  rx_entry_t  head,
  input  logic       any_tag,
  input  logic       fifo_en,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  output logic [7:0] status
);

  logic oe_q, oe_d;
  logic ack_q, ack_d;
  logic show;

  always_comb begin
    oe_d = oe_q;
    if (ovr_evt)        oe_d = 1'b1;
    else if (rd_status) oe_d = 1'b0;

    ack_d = ack_q;
    if (flush || head_change)      ack_d = 1'b0;
    else if (rd_status && nonempty) ack_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      ack_q <= ack_d;
    end
  end

  assign show = nonempty && !ack_q;

  always_comb begin
    status          = '0;
    status[ST_DR]   = nonempty;
    status[ST_OE]   = oe_q;
    status[ST_PE]   = show && head.par;
    status[ST_FE]   = show && head.frm;
    status[ST_BI]   = show && head.brk;
    status[ST_THRE] = tx_hold_empty;
    status[ST_TEMT] = tx_hold_empty && tx_shift_empty;
    status[ST_QERR] = fifo_en && any_tag;
  end

  a_r5_oe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> oe_q);

  a_r4_oe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !ovr_evt) |=> !oe_q);

  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && nonempty && !head_change && !flush) |=> (status[4:2] == 3'b000));

endmodule

// File: rtl/rx_fifo_lsr.sv
module rx_fifo_lsr
  import rxls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       char_done,
  input  logic [7:0] char_data,
  input  logic       char_brk,
  input  logic       char_frm,
  input  logic       char_par,
  input  logic       rd_data,
  input  logic       rd_status,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  output logic [7:0] rd_byte,
  output logic [7:0] status
);

  logic          mode_q;
  logic          flush;
  logic          full;
  logic          nonempty;
  logic          pop;
  logic          push;
  logic          ovr;
  logic          over;
  logic          head_change;
  logic          any_tag;
  logic          tag_in;
  logic          tag_head;
  logic [CW-1:0] count;
  rx_entry_t     in_entry;
  rx_entry_t     head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  assign flush    = fifo_en ^ mode_q;
  assign nonempty = (count != '0);
  assign full     = fifo_en ? (count == CW'(DEPTH)) : nonempty;

  assign pop  = rd_data && nonempty && !flush;
  assign push = char_done && !flush && (!full || pop);
  assign ovr  = char_done && !flush && full && !pop;
  assign over = ovr && !fifo_en;

  assign head_change = pop || (push && !nonempty) || over;

  assign in_entry = '{data: char_data, brk: char_brk, frm: char_frm, par: char_par};
  assign tag_in   = char_brk | char_frm | char_par;
  assign tag_head = head.brk | head.frm | head.par;

  rxls_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (push),
    .wr_over  (over),
    .wr_entry (in_entry),
    .rd_en    (pop),
    .head     (head),
    .count    (count)
  );

  rxls_tagcnt #(.DEPTH(DEPTH)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .inc     (fifo_en && push && tag_in),
    .dec     (fifo_en && pop && tag_head),
    .any_tag (any_tag)
  );

  rxls_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .ovr_evt        (ovr),
    .rd_status      (rd_status),
    .head_change    (head_change),
    .nonempty       (nonempty),
    .head           (head),
    .any_tag        (any_tag),
    .fifo_en        (fifo_en),
    .tx_hold_empty  (tx_hold_empty),
    .tx_shift_empty (tx_shift_empty),
    .status         (status)
  );

  assign rd_byte = nonempty ? head.data : 8'h00;

  a_r5_drop_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && fifo_en) |=> $stable(count));

  a_r2_dr_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> status[ST_DR]);

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  a_r8_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush) |-> (count <= CW'(1)));

endmodule

// File: tb/sim_rx_fifo_lsr.sv
`timescale 1ns/1ps
module sim_rx_fifo_lsr;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, char_done, char_brk, char_frm, char_par;
  logic [7:0] char_data;
  logic       rd_data, rd_status, tx_hold_empty, tx_shift_empty;
  logic [7:0] rd_byte, status;

  int total = 0;
  int bad   = 0;
  logic [10:0] exp_q [$];

  always #4 clk = ~clk;

  rx_fifo_lsr #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .char_done(char_done),
    .char_data(char_data), .char_brk(char_brk), .char_frm(char_frm),
    .char_par(char_par), .rd_data(rd_data), .rd_status(rd_status),
    .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .rd_byte(rd_byte), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_char(input logic [7:0] d, input logic b, input logic f,
                           input logic p, input bit store);
    char_done = 1'b1; char_data = d; char_brk = b; char_frm = f; char_par = p;
    if (store) exp_q.push_back({d, b, f, p});
    @(negedge clk);
    char_done = 1'b0; char_brk = 1'b0; char_frm = 1'b0; char_par = 1'b0;
  endtask

  task automatic pulse_status();
    rd_status = 1'b1;
    @(negedge clk);
    rd_status = 1'b0;
  endtask

  task automatic read_check(input string req);
    logic [10:0] e;
    e = exp_q.pop_front();
    chk(rd_byte == e[10:3], req, rd_byte, e[10:3]);
    chk(status[4:2] == e[2:0], {req, " tags"}, status[4:2], e[2:0]);
    chk(status[0] == 1'b1, {req, " dr"}, status[0], 1);
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; char_done = 1'b0; char_data = 8'h00;
    char_brk = 1'b0; char_frm = 1'b0; char_par = 1'b0;
    rd_data = 1'b0; rd_status = 1'b0; tx_hold_empty = 1'b1; tx_shift_empty = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(status == 8'h60, "R1 status", status, 8'h60);
    chk(rd_byte == 8'h00, "R1 rd_byte", rd_byte, 0);

    // R2 R3 R7 order and per-entry tags
    push_char(8'h00, 1, 0, 0, 1);
    chk(status[0] == 1'b1, "R2 dr after first", status[0], 1);
    push_char(8'h42, 0, 1, 0, 1);
    push_char(8'h43, 0, 0, 0, 1);
    push_char(8'h44, 0, 0, 1, 1);
    chk(status[7] == 1'b1, "R7 tagged present", status[7], 1);
    read_check("R3 head brk");
    read_check("R3 head frm");
    read_check("R2 clean");
    chk(status[7] == 1'b1, "R7 last tagged remains", status[7], 1);
    read_check("R3 head par");
    chk(status[0] == 1'b0, "R2 dr cleared", status[0], 0);
    chk(status[7] == 1'b0, "R7 no tags", status[7], 0);
    chk(rd_byte == 8'h00, "R2 empty byte", rd_byte, 0);

    // R4 masking until head changes
    push_char(8'h51, 0, 1, 0, 1);
    chk(status[3] == 1'b1, "R3 frm at head", status[3], 1);
    pulse_status();
    chk(status[4:2] == 3'b000, "R4 masked", status[4:2], 0);
    chk(status[7] == 1'b1, "R7 still tagged", status[7], 1);
    push_char(8'h52, 0, 0, 1, 1);
    chk(status[4:2] == 3'b000, "R4 masked behind", status[4:2], 0);
    begin
      logic [10:0] e;
      e = exp_q.pop_front();
      chk(rd_byte == e[10:3], "R4 head byte", rd_byte, e[10:3]);
      rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
    end
    read_check("R4 new head unmasked");

    // R5 overrun when full
    for (int i = 0; i < DEPTH; i++) push_char(8'h10 + 8'(i), 0, 0, 0, 1);
    chk(status[1] == 1'b0, "R5 no oe at full", status[1], 0);
    push_char(8'hEE, 0, 0, 0, 0);
    chk(status[1] == 1'b1, "R5 oe set", status[1], 1);
    pulse_status();
    chk(status[1] == 1'b0, "R4 oe cleared", status[1], 0);
    for (int i = 0; i < DEPTH; i++) read_check("R5 drain");
    chk(status[0] == 1'b0, "R5 discarded char absent", status[0], 0);

    // R6 push with pop while full
    for (int i = 0; i < DEPTH; i++) push_char(8'h20 + 8'(i), 0, 0, 0, 1);
    begin
      logic [10:0] e;
      e = exp_q.pop_front();
      chk(rd_byte == e[10:3], "R6 head", rd_byte, e[10:3]);
      exp_q.push_back({8'h99, 3'b000});
      char_done = 1'b1; char_data = 8'h99; rd_data = 1'b1;
      @(negedge clk);
      char_done = 1'b0; rd_data = 1'b0;
    end
    chk(status[1] == 1'b0, "R6 no overrun", status[1], 0);
    // R4 overrun and status read together
    char_done = 1'b1; char_data = 8'h77; rd_status = 1'b1;
    @(negedge clk);
    char_done = 1'b0; rd_status = 1'b0;
    chk(status[1] == 1'b1, "R4 set wins", status[1], 1);
    for (int i = 0; i < DEPTH; i++) read_check("R6 drain");
    chk(status[0] == 1'b0, "R6 count kept", status[0], 0);
    pulse_status();

    // R9 transmit flags
    for (int k = 0; k < 4; k++) begin
      tx_hold_empty = k[0]; tx_shift_empty = k[1];
      #1;
      chk(status[6:5] == {k[0] & k[1], k[0]}, "R9 tx flags", status[6:5], {k[0] & k[1], k[0]});
    end
    tx_hold_empty = 1'b1; tx_shift_empty = 1'b1;
    @(negedge clk);

    // R10 mode change flushes
    push_char(8'h61, 0, 0, 0, 0);
    push_char(8'h62, 1, 0, 0, 0);
    fifo_en = 1'b0;
    @(negedge clk);
    chk(status[0] == 1'b0, "R10 flushed", status[0], 0);
    chk(status[7] == 1'b0, "R10 no tags", status[7], 0);

    // R8 single register overwrite
    push_char(8'hA1, 0, 1, 0, 0);
    chk(rd_byte == 8'hA1, "R8 hold", rd_byte, 8'hA1);
    chk(status[3] == 1'b1, "R8 frm shown", status[3], 1);
    chk(status[7] == 1'b0, "R7 off in single mode", status[7], 0);
    push_char(8'hA2, 0, 0, 0, 0);
    chk(status[1] == 1'b1, "R8 oe set", status[1], 1);
    chk(rd_byte == 8'hA2, "R8 overwritten", rd_byte, 8'hA2);
    chk(status[4:2] == 3'b000, "R8 new tags", status[4:2], 0);
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0;
    chk(status[0] == 1'b0, "R8 dr cleared", status[0], 0);
    chk(rd_byte == 8'h00, "R8 empty byte", rd_byte, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule